// File: doc/BRIEF.md
# Full-Bridge Gate Sequencer with Dead Time

This block turns a commanded bridge state (drive, slow decay, fast decay or off) into the four gate enables of one H-bridge: high and low side on leg A, high and low side on leg B. The phase input decides which leg sources current. A synchronous-rectification policy decides which transistors conduct while the load current recirculates.

Each leg resolves to a target of high, low or floating. Every time a leg's target changes, the leg turns both of its gates off at once and restarts its own dead-time counter. The counter advances on master-clock ticks, and only when it reaches zero does the new gate turn on. A gate that turns off never waits. A leg whose target does not change keeps its gate on without a break. The output-disable, idle, zero-current-code and fault inputs each force the whole bridge to float.

Top module: `bridge_gate_seq`

## Requirements
- R1: While reset is asserted and after it is released, all four gate outputs are 0 until a new target has waited out its dead time.
- R2: The command `cmd` is encoded as 00 drive, 01 slow decay, 10 fast decay and 11 off. In drive with `phase`=0, leg A settles low (`gate_al`) and leg B high (`gate_bh`); with `phase`=1, leg A settles high (`gate_ah`) and leg B low (`gate_bl`).
- R3: `dead_sel` codes 00, 01, 10 and 11 give N = 2, 3, 4 and 6 ticks. With `tick` held high, a leg whose target is registered at clock edge k turns its new gate on at edge k+N+1, and both of its gates are 0 from edge k until then.
- R4: The high and low gates of one leg are never 1 in the same cycle.
- R5: In slow decay with rectification conducting, the source leg moves to its low side and the sink leg stays low.
- R6: With `sr_mode` 00 or 01 (rectification off), slow decay floats the source leg and keeps the sink leg low, and fast decay floats both legs.
- R7: In fast decay with rectification conducting, both legs take the reverse of their drive state (source leg low, sink leg high).
- R8: With `sr_mode`=10, `zero_cur`=1 stops rectification and the legs that were rectifying float; `rev_at_limit` has no effect in this mode.
- R9: With `sr_mode`=11, `rev_at_limit`=1 stops rectification and the legs that were rectifying float; `zero_cur` has no effect in this mode.
- R10: `out_dis`=1, `idle_n`=0, `dac_zero`=1, `fault`=1 or the off command each drive all four gates to 0 at the next clock edge, with no dead time.
- R11: The dead-time counter advances only in cycles with `tick`=1. While `tick` stays low, a pending gate stays off.
- R12: A leg whose target does not change keeps its gate on without a gap while the other leg changes state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Master-clock tick enable for dead-time counting |
| cmd | input | 2 | Bridge command: drive, slow, fast, off |
| phase | input | 1 | Current direction select |
| zero_cur | input | 1 | Load current has reached zero |
| rev_at_limit | input | 1 | Reversed current has reached the trip level |
| sr_mode | input | 2 | Rectification policy: 0x off, 10 active, 11 passive |
| dead_sel | input | 2 | Dead-time code |
| out_dis | input | 1 | High forces all gates off |
| idle_n | input | 1 | Low (idle) forces all gates off |
| dac_zero | input | 1 | Current code is zero; bridge forced off |
| fault | input | 1 | Thermal or supply fault; bridge forced off |
| gate_ah | output | 1 | Leg A high-side gate enable |
| gate_al | output | 1 | Leg A low-side gate enable |
| gate_bh | output | 1 | Leg B high-side gate enable |
| gate_bl | output | 1 | Leg B low-side gate enable |

## Verification
The minimum-gap assertion assumes that the shortest configured dead time is at least two ticks, and that the command and mode inputs are synchronous to `clk`. The stimulus changes inputs only on the falling clock edge. The gap property relies on the smallest dead-time code, so it holds even when `dead_sel` changes while a count is running. The stimulus also runs one long window with `tick` held low, to confirm that no gate turns on early when ticks are sparse.

// File: rtl/gs_pkg.sv
package gs_pkg;
    typedef enum logic [1:0] {
        LEG_FLOAT = 2'b00,
        LEG_HIGH  = 2'b01,
        LEG_LOW   = 2'b10
    } leg_tgt_e;

    typedef enum logic [1:0] {
        CMD_DRIVE = 2'b00,
        CMD_SLOW  = 2'b01,
        CMD_FAST  = 2'b10,
        CMD_OFF   = 2'b11
    } bridge_cmd_e;
endpackage

// File: rtl/gs_target_decode.sv
module gs_target_decode
    import gs_pkg::*;
(
    input  logic [1:0] cmd_i,
    input  logic       phase_i,
    input  logic       zero_cur_i,
    input  logic       rev_lim_i,
    input  logic [1:0] sr_mode_i,
    input  logic       kill_i,
    output leg_tgt_e   tgt_a_o,
    output leg_tgt_e   tgt_b_o
);
    logic     rect_on;
    leg_tgt_e src_t, snk_t;

    // rectification conducts only in active/passive modes and until its stop condition
    assign rect_on = sr_mode_i[1] && !(sr_mode_i[0] ? rev_lim_i : zero_cur_i);

    always_comb begin
        src_t = LEG_FLOAT;
        snk_t = LEG_FLOAT;
        if (!kill_i) begin
            case (cmd_i)
                CMD_DRIVE: begin
                    src_t = LEG_HIGH;
                    snk_t = LEG_LOW;
                end
                CMD_SLOW: begin
                    src_t = rect_on ? LEG_LOW : LEG_FLOAT;
                    snk_t = LEG_LOW;
                end
                CMD_FAST: begin
                    src_t = rect_on ? LEG_LOW  : LEG_FLOAT;
                    snk_t = rect_on ? LEG_HIGH : LEG_FLOAT;
                end
                default: begin
                    src_t = LEG_FLOAT;
                    snk_t = LEG_FLOAT;
                end
            endcase
        end
    end

    // phase 1 makes leg A the source leg
    assign tgt_a_o = phase_i ? src_t : snk_t;
    assign tgt_b_o = phase_i ? snk_t : src_t;
endmodule

// File: rtl/gs_leg.sv
module gs_leg
    import gs_pkg::*;
#(
    parameter int DT_W    = 3,
    parameter int MIN_GAP = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_i,
    input  leg_tgt_e        target_i,
    input  logic [DT_W-1:0] dead_i,
    output logic            hi_o,
    output logic            lo_o
);
    typedef struct packed {
        leg_tgt_e        tgt;
        logic [DT_W-1:0] cnt;
        logic            hi;
        logic            lo;
    } leg_st_t;

    leg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (target_i != st_q.tgt) begin
            // break first, then wait the full dead time
            st_d.tgt = target_i;
            st_d.cnt = dead_i;
            st_d.hi  = 1'b0;
            st_d.lo  = 1'b0;
        end else if (st_q.cnt != '0) begin
            if (tick_i) st_d.cnt = st_q.cnt - 1'b1;
        end else begin
            st_d.hi = (st_q.tgt == LEG_HIGH);
            st_d.lo = (st_q.tgt == LEG_LOW);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.tgt <= LEG_FLOAT;
            st_q.cnt <= '0;
            st_q.hi  <= 1'b0;
            st_q.lo  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hi_o = st_q.hi;
    assign lo_o = st_q.lo;

    // off-run length seen at the outputs, used only by the gap check
    logic [3:0] gap_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                  gap_q <= '0;
        else if (st_q.hi || st_q.lo) gap_q <= '0;
        else if (gap_q != 4'hF)      gap_q <= gap_q + 1'b1;
    end

    a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_o && lo_o));

    a_r3_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hi_o) || $rose(lo_o)) |-> (gap_q >= 4'(MIN_GAP)));

    a_r2_high_needs_target: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hi_o) |-> ($past(target_i) == LEG_HIGH));

    a_r2_low_needs_target: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lo_o) |-> ($past(target_i) == LEG_LOW));
endmodule

// File: rtl/bridge_gate_seq.sv
module bridge_gate_seq
    import gs_pkg::*;
#(
    parameter int DT_W    = 3,
    parameter int DEAD_T0 = 2,
    parameter int DEAD_T1 = 3,
    parameter int DEAD_T2 = 4,
    parameter int DEAD_T3 = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] cmd,
    input  logic       phase,
    input  logic       zero_cur,
    input  logic       rev_at_limit,
    input  logic [1:0] sr_mode,
    input  logic [1:0] dead_sel,
    input  logic       out_dis,
    input  logic       idle_n,
    input  logic       dac_zero,
    input  logic       fault,
    output logic       gate_ah,
    output logic       gate_al,
    output logic       gate_bh,
    output logic       gate_bl
);
    localparam int NLEG  = 2;
    localparam int MIN01 = (DEAD_T0 < DEAD_T1) ? DEAD_T0 : DEAD_T1;
    localparam int MIN23 = (DEAD_T2 < DEAD_T3) ? DEAD_T2 : DEAD_T3;
    localparam int MIN_DEAD = (MIN01 < MIN23) ? MIN01 : MIN23;

    logic            kill;
    logic [DT_W-1:0] dead_cnt;
    leg_tgt_e        tgt [NLEG];
    logic            hi  [NLEG];
    logic            lo  [NLEG];

    assign kill = out_dis || !idle_n || dac_zero || fault;

    always_comb begin
        case (dead_sel)
            2'b00:   dead_cnt = DT_W'(DEAD_T0);
            2'b01:   dead_cnt = DT_W'(DEAD_T1);
            2'b10:   dead_cnt = DT_W'(DEAD_T2);
            default: dead_cnt = DT_W'(DEAD_T3);
        endcase
    end

    gs_target_decode u_dec (
        .cmd_i      (cmd),
        .phase_i    (phase),
        .zero_cur_i (zero_cur),
        .rev_lim_i  (rev_at_limit),
        .sr_mode_i  (sr_mode),
        .kill_i     (kill),
        .tgt_a_o    (tgt[0]),
        .tgt_b_o    (tgt[1])
    );

    for (genvar g = 0; g < NLEG; g++) begin : g_leg
        gs_leg #(
            .DT_W    (DT_W),
            .MIN_GAP (MIN_DEAD)
        ) u_leg (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_i   (tick),
            .target_i (tgt[g]),
            .dead_i   (dead_cnt),
            .hi_o     (hi[g]),
            .lo_o     (lo[g])
        );
    end

    assign gate_ah = hi[0];
    assign gate_al = lo[0];
    assign gate_bh = hi[1];
    assign gate_bl = lo[1];

    a_r10_kill_all_off: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> !(gate_ah || gate_al || gate_bh || gate_bl));

    a_r10_off_cmd_all_off: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'b11) |=> !(gate_ah || gate_al || gate_bh || gate_bl));
endmodule

// File: tb/bridge_gate_seq_test.sv
`timescale 1ns/1ps
module bridge_gate_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic [1:0] cmd = 2'b11;
    logic       phase = 1'b0;
    logic       zero_cur = 1'b0;
    logic       rev_at_limit = 1'b0;
    logic [1:0] sr_mode = 2'b10;
    logic [1:0] dead_sel = 2'b00;
    logic       out_dis = 1'b0;
    logic       idle_n = 1'b1;
    logic       dac_zero = 1'b0;
    logic       fault = 1'b0;
    logic       gate_ah, gate_al, gate_bh, gate_bl;

    bridge_gate_seq uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cmd(cmd), .phase(phase),
        .zero_cur(zero_cur), .rev_at_limit(rev_at_limit), .sr_mode(sr_mode),
        .dead_sel(dead_sel), .out_dis(out_dis), .idle_n(idle_n),
        .dac_zero(dac_zero), .fault(fault),
        .gate_ah(gate_ah), .gate_al(gate_al), .gate_bh(gate_bh), .gate_bl(gate_bl)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        int         due;
        logic [3:0] exp;
        string      tag;
    } item_t;

    item_t sb[$];
    int    cyc = 0;
    int    n_run = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    // expected vectors are {ah, al, bh, bl}
    task automatic push(input int due, input logic [3:0] exp, input string tag);
        item_t it;
        it.due = due;
        it.exp = exp;
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic wait_to(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    // inputs were changed at this falling edge; a changing leg is off at c+1 and on at c+n+2
    task automatic step(input string tag, input int n, input logic [3:0] mid, input logic [3:0] fin);
        int c;
        c = cyc;
        push(c + 1, mid, tag);
        push(c + n + 1, mid, tag);
        push(c + n + 2, fin, tag);
        wait_to(c + n + 3);
    endtask

    task automatic kill_step(input string tag);
        int c;
        c = cyc;
        push(c + 1, 4'b0000, tag);
        push(c + 8, 4'b0000, tag);
        wait_to(c + 9);
    endtask

    // monitor: samples one time unit after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            cyc = cyc + 1;
            #1;
            while (sb.size() > 0 && sb[0].due <= cyc) begin
                item_t it;
                logic [3:0] act;
                it = sb.pop_front();
                act = {gate_ah, gate_al, gate_bh, gate_bl};
                n_run++;
                if (it.due != cyc || act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s cycle %0d: actual %b expected %b", it.tag, cyc, act, it.exp);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        push(cyc + 1, 4'b0000, "R1 in reset");
        @(negedge clk);
        rst_n = 1'b1;
        push(cyc + 2, 4'b0000, "R1 after reset");
        wait_to(cyc + 3);

        // R2 drive, phase 0, N=2
        cmd = 2'b00; phase = 1'b0; dead_sel = 2'b00;
        step("R2 drive phase0", 2, 4'b0000, 4'b0110);
        // R5 / R12 slow decay, active rectification conducting
        cmd = 2'b01;
        step("R5 R12 slow rectify", 2, 4'b0100, 4'b0101);
        // R8 zero current stops active rectification
        zero_cur = 1'b1;
        step("R8 zero stops", 2, 4'b0100, 4'b0100);
        // R8 reversed-at-limit ignored in active mode
        zero_cur = 1'b0; rev_at_limit = 1'b1;
        step("R8 rev ignored", 2, 4'b0100, 4'b0101);
        // R9 passive: reversed-at-limit stops
        sr_mode = 2'b11;
        step("R9 rev stops", 2, 4'b0100, 4'b0100);
        // R9 zero current ignored in passive mode
        rev_at_limit = 1'b0; zero_cur = 1'b1;
        step("R9 zero ignored", 2, 4'b0100, 4'b0101);
        // R2 / R3 drive phase 1, N=6
        zero_cur = 1'b0; cmd = 2'b00; phase = 1'b1; dead_sel = 2'b11;
        step("R2 R3 drive phase1 N6", 6, 4'b0001, 4'b1001);
        // R7 fast decay rectifying, N=4
        cmd = 2'b10; dead_sel = 2'b10;
        step("R7 R3 fast rectify N4", 4, 4'b0000, 4'b0110);
        // R6 fast decay, rectification off
        sr_mode = 2'b00;
        step("R6 fast no rect", 4, 4'b0000, 4'b0000);
        // R6 slow decay, code 01, N=3
        cmd = 2'b01; sr_mode = 2'b01; dead_sel = 2'b01;
        step("R6 slow no rect N3", 3, 4'b0000, 4'b0001);
        // R2 drive phase 0, N=3
        cmd = 2'b00; phase = 1'b0;
        step("R2 R3 drive N3", 3, 4'b0000, 4'b0110);

        // R10 forced-off inputs and off command
        out_dis = 1'b1;  kill_step("R10 out_dis");
        out_dis = 1'b0;  step("R10 out_dis release", 3, 4'b0000, 4'b0110);
        idle_n = 1'b0;   kill_step("R10 idle");
        idle_n = 1'b1;   step("R10 idle release", 3, 4'b0000, 4'b0110);
        dac_zero = 1'b1; kill_step("R10 dac_zero");
        dac_zero = 1'b0; step("R10 dac release", 3, 4'b0000, 4'b0110);
        fault = 1'b1;    kill_step("R10 fault");
        fault = 1'b0;    step("R10 fault release", 3, 4'b0000, 4'b0110);
        cmd = 2'b11;     kill_step("R10 off cmd");
        cmd = 2'b00;     step("R10 off release", 3, 4'b0000, 4'b0110);

        // R11 no ticks: pending gates stay off
        begin
            int c;
            c = cyc;
            tick = 1'b0; phase = 1'b1;
            push(c + 1, 4'b0000, "R11 hold");
            push(c + 12, 4'b0000, "R11 hold long");
            wait_to(c + 12);
            tick = 1'b1;
            push(c + 15, 4'b0000, "R11 resume");
            push(c + 16, 4'b1001, "R11 resume on");
            wait_to(c + 18);
        end

        wait_to(cyc + 2);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule